// File: doc/BRIEF.md
# BCD Clock Calendar Counter Chain

This block holds wall-clock time and calendar date as packed-BCD fields: seconds, minutes, hours (24-hour), day of week, day of month, month and a two-digit year. A single-cycle `tick` strobe, expected once per second from a divided oscillator, advances the seconds field. Every carry that this causes ripples through the whole chain within the same clock cycle. The day-of-month limit depends on the month, and February depends on whether the year is a leap year.

Software loads any field through a byte-wide write port and reads any field through a combinational read port. Both ports use the same small address map. Bit 7 of the seconds byte is a sticky integrity flag. It is set at reset and by the `oscFail` strobe, and it stays set until software writes a 0 into that bit. While the flag is 1, the time should be treated as suspect. Results for fields loaded with values that are not valid BCD, or with an impossible date, are undefined.

Top module: `bcd_clock_calendar`

## Requirements
- R1: Seconds and minutes count in BCD through 00..59. A step from 59 returns the field to 00 and advances the next field; a step from x9 moves to (x+1)0.
- R2: Hours count in BCD through 00..23. A step from 23 returns to 00 and advances both the day-of-month and the day-of-week fields in the same cycle.
- R3: Day of week counts 0..6 and then returns to 0. It sits in bits 2:0 of address 0x06, and bits 7:3 read 0.
- R4: Day of month runs 01..31 in months 01, 03, 05, 07, 08, 10 and 12, and 01..30 in months 04, 06, 09 and 11. A step past the last day returns it to 01 and advances the month.
- R5: In month 02 the day of month runs to 29 when the year is a multiple of four (00 included), and to 28 otherwise.
- R6: Month counts in BCD through 01..12 and advances the year when it returns to 01. Year counts in BCD through 00..99 and wraps to 00.
- R7: Address map: 0x02 seconds, 0x03 minutes, 0x04 hours, 0x05 day of month, 0x06 day of week, 0x07 month, 0x08 year. Bits a field does not implement read 0. Any other address reads 0x00, and writes to it change nothing.
- R8: The flag in bit 7 of 0x02 is set by `oscFail`. It is cleared only by a write to 0x02 with bit 7 = 0, and a write with bit 7 = 1 leaves it as it was. `oscFail` wins over a clearing write in the same cycle.
- R9: After reset the fields read seconds 0x80 (flag set), minutes 0x00, hours 0x00, day of month 0x01, day of week 0x00, month 0x01, year 0x00.
- R10: A write to a field takes priority over a tick in the same cycle. The written field takes the written value and passes no carry on, while the fields below it still advance.
- R11: A tick's full carry ripple is visible on the read port in the first cycle after the tick. Without a tick, a write or `oscFail`, no field changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe that advances the seconds field |
| oscFail | input | 1 | One-cycle strobe that sets the integrity flag |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | 8 | Write data (packed BCD) |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | 8 | Read data for `rdAddr`, combinational |

## Verification
A software write and a tick can land in the same clock cycle. The bench forces this by raising `wrEn` and `tick` on the same falling edge. In one case it writes minutes while the seconds field sits at 59. It then expects seconds at 00, minutes at the written value and hours unchanged, showing that the carry into the written field was dropped. In the other case it writes seconds at 59 and expects the written value with minutes unchanged. A clearing write to the seconds byte that coincides with `oscFail` is judged the same way: the flag must read back as set.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;
  localparam int NUM_FIELDS = 7;
  localparam int REG_BASE   = 2;

  typedef enum logic [2:0] {
    FLD_SEC, FLD_MIN, FLD_HOUR, FLD_DATE, FLD_WDAY, FLD_MONTH, FLD_YEAR
  } calField_e;

  typedef struct packed {
    logic                  tick;
    logic                  setOsf;
    logic                  clrOsf;
    logic [NUM_FIELDS-1:0] ld;
  } calStrobes_t;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic isLeapYear(input logic [7:0] yr);
    logic [6:0] bin;
    bin = {3'b0, yr[7:4]} * 7'd10 + {3'b0, yr[3:0]};
    return bin[1:0] == 2'b00;
  endfunction

  function automatic logic [5:0] lastDay(input logic [4:0] mon, input logic [7:0] yr);
    case (mon)
      5'h02:                      return isLeapYear(yr) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_bcd_cnt.sv
`timescale 1ns/1ps
module cal_bcd_cnt #(
  parameter int         W   = 8,
  parameter logic [W-1:0] LO  = '0,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inc,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  input  logic [W-1:0] maxVal,
  output logic [W-1:0] value,
  output logic         carry
);
  import cal_pkg::*;

  logic [7:0]   wide;
  logic [7:0]   wideInc;
  logic [W-1:0] nextVal;
  logic         atMax;

  assign wide    = 8'(value);
  assign wideInc = bcdInc(wide);
  assign atMax   = (value == maxVal);
  assign carry   = inc && !load && atMax;

  always_comb begin
    nextVal = value;
    if (load)       nextVal = loadVal;
    else if (inc)   nextVal = atMax ? LO : wideInc[W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) value <= RST;
    else       value <= nextVal;
  end
endmodule

// File: rtl/cal_ctrl.sv
`timescale 1ns/1ps
module cal_ctrl #(
  parameter int ADDR_W = 4
) (
  input  logic                 tick,
  input  logic                 oscFail,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic                 wrFlagBit,
  output cal_pkg::calStrobes_t strobes
);
  import cal_pkg::*;

  logic [NUM_FIELDS-1:0] ldVec;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_dec
    assign ldVec[i] = wrEn && (wrAddr == ADDR_W'(REG_BASE + i));
  end

  always_comb begin
    strobes.tick   = tick;
    strobes.setOsf = oscFail;
    strobes.clrOsf = ldVec[FLD_SEC] && !wrFlagBit;
    strobes.ld     = ldVec;
  end
endmodule

// File: rtl/cal_datapath.sv
`timescale 1ns/1ps
module cal_datapath #(
  parameter int ADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cal_pkg::calStrobes_t s,
  input  logic [7:0]           wrData,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [7:0]           rdData
);
  import cal_pkg::*;

  localparam logic [ADDR_W-1:0] A_SEC   = ADDR_W'(REG_BASE + FLD_SEC);
  localparam logic [ADDR_W-1:0] A_MIN   = ADDR_W'(REG_BASE + FLD_MIN);
  localparam logic [ADDR_W-1:0] A_HOUR  = ADDR_W'(REG_BASE + FLD_HOUR);
  localparam logic [ADDR_W-1:0] A_DATE  = ADDR_W'(REG_BASE + FLD_DATE);
  localparam logic [ADDR_W-1:0] A_WDAY  = ADDR_W'(REG_BASE + FLD_WDAY);
  localparam logic [ADDR_W-1:0] A_MONTH = ADDR_W'(REG_BASE + FLD_MONTH);
  localparam logic [ADDR_W-1:0] A_YEAR  = ADDR_W'(REG_BASE + FLD_YEAR);

  logic [6:0] secVal, minVal;
  logic [5:0] hourVal, dateVal;
  logic [4:0] monVal;
  logic [7:0] yearVal;
  logic [2:0] wdayVal;
  logic       osfFlag;
  logic       secCarry, minCarry, hourCarry, dateCarry, monCarry, yearCarry;
  logic [5:0] dateMax;
  logic       anyLd;

  assign dateMax = lastDay(monVal, yearVal);
  assign anyLd   = |s.ld;

  cal_bcd_cnt #(.W(7), .LO(7'h00), .RST(7'h00)) uSec (
    .clk(clk), .rstN(rstN), .inc(s.tick), .load(s.ld[FLD_SEC]),
    .loadVal(wrData[6:0]), .maxVal(7'h59), .value(secVal), .carry(secCarry));

  cal_bcd_cnt #(.W(7), .LO(7'h00), .RST(7'h00)) uMin (
    .clk(clk), .rstN(rstN), .inc(secCarry), .load(s.ld[FLD_MIN]),
    .loadVal(wrData[6:0]), .maxVal(7'h59), .value(minVal), .carry(minCarry));

  cal_bcd_cnt #(.W(6), .LO(6'h00), .RST(6'h00)) uHour (
    .clk(clk), .rstN(rstN), .inc(minCarry), .load(s.ld[FLD_HOUR]),
    .loadVal(wrData[5:0]), .maxVal(6'h23), .value(hourVal), .carry(hourCarry));

  cal_bcd_cnt #(.W(6), .LO(6'h01), .RST(6'h01)) uDate (
    .clk(clk), .rstN(rstN), .inc(hourCarry), .load(s.ld[FLD_DATE]),
    .loadVal(wrData[5:0]), .maxVal(dateMax), .value(dateVal), .carry(dateCarry));

  cal_bcd_cnt #(.W(5), .LO(5'h01), .RST(5'h01)) uMonth (
    .clk(clk), .rstN(rstN), .inc(dateCarry), .load(s.ld[FLD_MONTH]),
    .loadVal(wrData[4:0]), .maxVal(5'h12), .value(monVal), .carry(monCarry));

  cal_bcd_cnt #(.W(8), .LO(8'h00), .RST(8'h00)) uYear (
    .clk(clk), .rstN(rstN), .inc(monCarry), .load(s.ld[FLD_YEAR]),
    .loadVal(wrData), .maxVal(8'h99), .value(yearVal), .carry(yearCarry));

  // Weekday: free-running modulo-7 driven by the midnight carry
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                wdayVal <= 3'd0;
    else if (s.ld[FLD_WDAY])  wdayVal <= wrData[2:0];
    else if (hourCarry)       wdayVal <= (wdayVal == 3'd6) ? 3'd0 : wdayVal + 3'd1;
  end

  // Sticky integrity flag: set wins over a clearing write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          osfFlag <= 1'b1;
    else if (s.setOsf)  osfFlag <= 1'b1;
    else if (s.clrOsf)  osfFlag <= 1'b0;
  end

  always_comb begin
    case (rdAddr)
      A_SEC:   rdData = {osfFlag, secVal};
      A_MIN:   rdData = {1'b0, minVal};
      A_HOUR:  rdData = {2'b0, hourVal};
      A_DATE:  rdData = {2'b0, dateVal};
      A_WDAY:  rdData = {5'b0, wdayVal};
      A_MONTH: rdData = {3'b0, monVal};
      A_YEAR:  rdData = yearVal;
      default: rdData = 8'h00;
    endcase
  end

  logic unusedCarry;
  assign unusedCarry = yearCarry;

  assert_sec_wrap_R1: assert property (@(posedge clk) disable iff (!rstN)
    (s.tick && !anyLd && secVal == 7'h59) |=> (secVal == 7'h00 && minVal != $past(minVal)));

  assert_midnight_R2: assert property (@(posedge clk) disable iff (!rstN)
    (s.tick && !anyLd && secVal == 7'h59 && minVal == 7'h59 && hourVal == 6'h23)
    |=> (hourVal == 6'h00 && dateVal != $past(dateVal) && wdayVal != $past(wdayVal)));

  assert_wday_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (s.tick && !anyLd && secVal == 7'h59 && minVal == 7'h59 && hourVal == 6'h23 && wdayVal == 3'd6)
    |=> (wdayVal == 3'd0));

  assert_osf_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    s.setOsf |=> osfFlag);

  assert_osf_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (osfFlag && !s.clrOsf) |=> osfFlag);

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    s.ld[FLD_MIN] |=> (minVal == $past(wrData[6:0])));

  assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!s.tick && !anyLd && !s.setOsf) |=> ($stable(secVal) && $stable(minVal) && $stable(hourVal)
      && $stable(dateVal) && $stable(wdayVal) && $stable(monVal) && $stable(yearVal) && $stable(osfFlag)));
endmodule

// File: rtl/bcd_clock_calendar.sv
`timescale 1ns/1ps
module bcd_clock_calendar #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              oscFail,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData
);
  import cal_pkg::*;

  calStrobes_t strobes;

  cal_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .tick(tick), .oscFail(oscFail), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrFlagBit(wrData[7]), .strobes(strobes));

  cal_datapath #(.ADDR_W(ADDR_W)) uPath (
    .clk(clk), .rstN(rstN), .s(strobes), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData));
endmodule

// File: tb/bcd_clock_calendar_bench.sv
`timescale 1ns/1ps
module bcd_clock_calendar_bench;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              tick = 1'b0;
  logic              oscFail = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [7:0]        wrData = '0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [7:0]        rdData;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  bcd_clock_calendar #(.ADDR_W(ADDR_W)) u_bcd_clock_calendar (
    .clk(clk), .rstN(rstN), .tick(tick), .oscFail(oscFail), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData));

  localparam logic [3:0] A_SEC = 4'h2, A_MIN = 4'h3, A_HOUR = 4'h4, A_DATE = 4'h5,
                         A_WDAY = 4'h6, A_MON = 4'h7, A_YEAR = 4'h8;

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic readChk(input string tag, input logic [3:0] addr, input logic [7:0] exp);
    rdAddr = addr;
    #0.2;
    check(tag, rdData, exp);
  endtask

  task automatic writeReg(input logic [3:0] addr, input logic [7:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = addr; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doTick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic tickWithWrite(input logic [3:0] addr, input logic [7:0] data);
    @(negedge clk);
    tick = 1'b1; wrEn = 1'b1; wrAddr = addr; wrData = data;
    @(negedge clk);
    tick = 1'b0; wrEn = 1'b0;
  endtask

  task automatic setAll(input logic [7:0] yr, input logic [7:0] mo, input logic [7:0] d,
                        input logic [7:0] w, input logic [7:0] h, input logic [7:0] m,
                        input logic [7:0] s);
    writeReg(A_YEAR, yr); writeReg(A_MON, mo); writeReg(A_DATE, d);
    writeReg(A_WDAY, w);  writeReg(A_HOUR, h); writeReg(A_MIN, m); writeReg(A_SEC, s);
  endtask

  task automatic testReset();
    readChk("R9 sec+flag", A_SEC, 8'h80);
    readChk("R9 min", A_MIN, 8'h00);
    readChk("R9 hour", A_HOUR, 8'h00);
    readChk("R9 date", A_DATE, 8'h01);
    readChk("R9 wday", A_WDAY, 8'h00);
    readChk("R9 month", A_MON, 8'h01);
    readChk("R9 year", A_YEAR, 8'h00);
    readChk("R7 unmapped 0x0", 4'h0, 8'h00);
    readChk("R7 unmapped 0xF", 4'hF, 8'h00);
  endtask

  task automatic testSecMin();
    setAll(8'h21, 8'h03, 8'h10, 8'h02, 8'h10, 8'h41, 8'h09);
    doTick();
    readChk("R1 sec x9 step", A_SEC, 8'h10);
    writeReg(A_SEC, 8'h59); writeReg(A_MIN, 8'h59);
    doTick();
    readChk("R1 sec wrap", A_SEC, 8'h00);
    readChk("R1 min wrap", A_MIN, 8'h00);
    readChk("R1 hour carry", A_HOUR, 8'h11);
    readChk("R1 date untouched", A_DATE, 8'h10);
  endtask

  task automatic testMidnight();
    setAll(8'h21, 8'h05, 8'h15, 8'h06, 8'h23, 8'h59, 8'h59);
    doTick();
    readChk("R2 hour wrap", A_HOUR, 8'h00);
    readChk("R2 date carry", A_DATE, 8'h16);
    readChk("R3 wday 6->0", A_WDAY, 8'h00);
    readChk("R2 month same", A_MON, 8'h05);
    writeReg(A_WDAY, 8'h03);
    writeReg(A_HOUR, 8'h23); writeReg(A_MIN, 8'h59); writeReg(A_SEC, 8'h59);
    doTick();
    readChk("R3 wday 3->4", A_WDAY, 8'h04);
  endtask

  task automatic testMonthEnds();
    setAll(8'h21, 8'h04, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
    doTick();
    readChk("R4 30-day month date", A_DATE, 8'h01);
    readChk("R4 30-day month month", A_MON, 8'h05);
    setAll(8'h21, 8'h01, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
    doTick();
    readChk("R4 31-day month keeps 31", A_DATE, 8'h31);
    readChk("R4 31-day month no carry", A_MON, 8'h01);
    setAll(8'h21, 8'h09, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
    doTick();
    readChk("R6 month 09->10 bcd", A_MON, 8'h10);
    setAll(8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
    doTick();
    readChk("R11 full ripple sec", A_SEC, 8'h00);
    readChk("R11 full ripple min", A_MIN, 8'h00);
    readChk("R11 full ripple hour", A_HOUR, 8'h00);
    readChk("R6 date new year", A_DATE, 8'h01);
    readChk("R6 month wrap", A_MON, 8'h01);
    readChk("R6 year 99->00", A_YEAR, 8'h00);
    readChk("R3 wday new year", A_WDAY, 8'h06);
  endtask

  task automatic febCase(input logic [7:0] yr, input logic [7:0] expDate, input logic [7:0] expMon,
                         input string tag);
    setAll(yr, 8'h02, 8'h28, 8'h00, 8'h23, 8'h59, 8'h59);
    doTick();
    readChk({tag, " date"}, A_DATE, expDate);
    readChk({tag, " month"}, A_MON, expMon);
  endtask

  task automatic testFebruary();
    febCase(8'h23, 8'h01, 8'h03, "R5 year 23");
    febCase(8'h24, 8'h29, 8'h02, "R5 year 24");
    writeReg(A_HOUR, 8'h23); writeReg(A_MIN, 8'h59); writeReg(A_SEC, 8'h59);
    doTick();
    readChk("R5 leap 29->1", A_DATE, 8'h01);
    readChk("R5 leap month", A_MON, 8'h03);
    febCase(8'h00, 8'h29, 8'h02, "R5 year 00");
    febCase(8'h10, 8'h01, 8'h03, "R5 year 10");
    febCase(8'h12, 8'h29, 8'h02, "R5 year 12");
  endtask

  task automatic testFlag();
    writeReg(A_SEC, 8'h30);
    readChk("R8 cleared by 0", A_SEC, 8'h30);
    @(negedge clk); oscFail = 1'b1; @(negedge clk); oscFail = 1'b0;
    readChk("R8 set by strobe", A_SEC, 8'hB0);
    doTick();
    readChk("R8 survives tick", A_SEC, 8'hB1);
    writeReg(A_SEC, 8'hC5);
    readChk("R8 write 1 keeps", A_SEC, 8'hC5);
    @(negedge clk);
    oscFail = 1'b1; wrEn = 1'b1; wrAddr = A_SEC; wrData = 8'h45;
    @(negedge clk);
    oscFail = 1'b0; wrEn = 1'b0;
    readChk("R8 strobe beats clear", A_SEC, 8'hC5);
  endtask

  task automatic testCollision();
    setAll(8'h21, 8'h06, 8'h12, 8'h02, 8'h08, 8'h20, 8'h59);
    tickWithWrite(A_MIN, 8'h10);
    readChk("R10 sec still advances", A_SEC, 8'h00);
    readChk("R10 written min", A_MIN, 8'h10);
    readChk("R10 hour no carry", A_HOUR, 8'h08);
    writeReg(A_SEC, 8'h59);
    tickWithWrite(A_SEC, 8'h20);
    readChk("R10 written sec", A_SEC, 8'h20);
    readChk("R10 min no carry", A_MIN, 8'h10);
  endtask

  task automatic testMapAndIdle();
    setAll(8'h21, 8'h06, 8'h12, 8'h02, 8'h08, 8'h20, 8'h33);
    writeReg(4'h9, 8'hFF);
    writeReg(4'h1, 8'h00);
    readChk("R7 stray write sec", A_SEC, 8'h33);
    readChk("R7 stray write min", A_MIN, 8'h20);
    readChk("R7 stray write year", A_YEAR, 8'h21);
    readChk("R7 stray write month", A_MON, 8'h06);
    writeReg(A_MIN, 8'h85);
    readChk("R7 min bit7 reads 0", A_MIN, 8'h05);
    writeReg(A_WDAY, 8'hF3);
    readChk("R3 wday high bits 0", A_WDAY, 8'h03);
    writeReg(A_MON, 8'hE9);
    readChk("R7 month high bits 0", A_MON, 8'h09);
    repeat (20) @(negedge clk);
    readChk("R11 idle sec", A_SEC, 8'h33);
    readChk("R11 idle date", A_DATE, 8'h12);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSecMin();
    testMidnight();
    testMonthEnds();
    testFebruary();
    testFlag();
    testCollision();
    testMapAndIdle();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule